// File: doc/BRIEF.md
# Bus transfer saturation limiter

This block sits on the data path that carries wide accumulator contents out to memory. Each source value is 40 bits wide and comes with a limit flag that was computed earlier, plus a strobe that marks the transfer as a limiting one. When both the strobe and the flag are set, the block does not place the normal data on the bus. It places the largest value of the same sign that fits the transfer width. The source register is never written back, so only the copy on the bus is saturated and the original value stays available for later arithmetic.

Each bus has four 16-bit limiter lanes. A per-bus mode bit joins the lanes in pairs, giving two 32-bit limiters for long-word transfers. Two buses run side by side, so up to eight operands are limited independently in one cycle. The limiting decision is combinational and is followed by one output register stage. This gives a fixed latency of one clock. Each lane also reports whether a substitution took place.

Top module: `xfer_lim_top`

## Requirements
- R1: While `rst_n` is low and on the first edge after it, every output word and every `sat_o` bit is 0.
- R2: In word mode (`long_i` bit of the bus = 0), a lane whose `en_i` and `flag_i` are both 1 and whose source bit 39 is 0 outputs 0x7FFF with its `sat_o` bit at 1.
- R3: In word mode, a lane whose `en_i` and `flag_i` are both 1 and whose source bit 39 is 1 outputs 0x8000 with `sat_o` at 1.
- R4: In word mode, a lane with `en_i` = 0 or `flag_i` = 0 outputs source bits 31..16 with `sat_o` at 0.
- R5: In long mode (`long_i` = 1), pair k uses the inputs of lane 2k. If that lane's `en_i` and `flag_i` are both 1, the 32-bit result is 0x7FFF_FFFF when source bit 39 is 0 and 0x8000_0000 when it is 1. The low half goes to lane 2k and the high half to lane 2k+1.
- R6: In long mode with no substitution, lane 2k outputs source bits 15..0 of lane 2k and lane 2k+1 outputs bits 31..16 of lane 2k.
- R7: In long mode, the source, `flag_i` and `en_i` of lane 2k+1 have no effect on any output.
- R8: The sign of a substituted value comes only from source bit 39, whatever bits 38..31 hold.
- R9: Lanes decide independently, and the two buses use their own mode bits independently.
- R10: Outputs change exactly one clock edge after the inputs they reflect, and hold between edges.
- R11: In long mode, both lanes of a pair show the same `sat_o` value, which is 1 exactly when the pair substituted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| long_i | input | 2 | Per-bus mode: 1 pairs lanes into 32-bit limiters |
| src_i | input | 320 | 40-bit source per lane; lane n at bits 40n+39..40n; bus b holds lanes 4b..4b+3 |
| flag_i | input | 8 | Per-lane limit flag of the source register |
| en_i | input | 8 | Per-lane strobe marking a limiting transfer |
| word_o | output | 128 | 16-bit transferred word per lane, lane n at bits 16n+15..16n |
| sat_o | output | 8 | Per-lane indication that a saturated value was substituted |

## Verification
Lanes are driven with positive and negative sources whose pass-through bits differ from both limit patterns. This shows whether a substitution happened at all, and which sign was chosen. Sources with bit 39 set but bits 38..31 clear, and the reverse, tell a sign taken from bit 39 apart from one taken from the pass-through field. Strobe-only and flag-only cases separate the two gating conditions. In long mode the odd lane is given contradictory inputs, which exposes any pair that reads the wrong lane. A run of pseudo-random mixed-mode patterns compares all eight lanes against a model built from the requirements, and a before-and-after-edge sample pins the latency.

// File: rtl/xfer_lim_pkg.sv
package xfer_lim_pkg;

   // per-bus grouping of limiter lanes
   typedef enum logic {
      MODE_WORD = 1'b0,
      MODE_LONG = 1'b1
   } xfer_mode_e;

   localparam int unsigned DEF_NUM_BUS = 2;
   localparam int unsigned DEF_LANES   = 4;
   localparam int unsigned DEF_SRC_W   = 40;
   localparam int unsigned DEF_WORD_W  = 16;

endpackage

// File: rtl/xfer_lim_cell.sv
// One saturating limiter of OUT_W bits. Substitutes a full-scale value of the
// source sign when the transfer is a limiting one and the flag is set.
module xfer_lim_cell #(
   parameter int unsigned OUT_W = 16
) (
   input  logic             sign_i,
   input  logic [OUT_W-1:0] pass_i,
   input  logic             flag_i,
   input  logic             en_i,
   output logic [OUT_W-1:0] word_o,
   output logic             hit_o
);

   localparam logic [OUT_W-1:0] POS_FULL = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_FULL = {1'b1, {(OUT_W-1){1'b0}}};

   initial begin
      assert (OUT_W >= 2) else $error("xfer_lim_cell: OUT_W must be at least 2");
   end

   always_comb begin
      hit_o = flag_i & en_i;
      if (hit_o) begin
         word_o = sign_i ? NEG_FULL : POS_FULL;
      end else begin
         word_o = pass_i;
      end
   end

endmodule

// File: rtl/xfer_lim_bus.sv
// One bus: LANES word limiters plus LANES/2 long limiters, a mode mux and
// the output register stage.
module xfer_lim_bus
   import xfer_lim_pkg::*;
#(
   parameter int unsigned LANES  = DEF_LANES,
   parameter int unsigned SRC_W  = DEF_SRC_W,
   parameter int unsigned WORD_W = DEF_WORD_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    long_i,
   input  logic [LANES*SRC_W-1:0]  src_i,
   input  logic [LANES-1:0]        flag_i,
   input  logic [LANES-1:0]        en_i,
   output logic [LANES*WORD_W-1:0] word_o,
   output logic [LANES-1:0]        sat_o
);

   localparam int unsigned PAIRS    = LANES / 2;
   localparam int unsigned LONG_W   = 2 * WORD_W;
   localparam int unsigned PASS_MSB = LONG_W - 1;
   localparam int unsigned SIGN_BIT = SRC_W - 1;
   localparam int unsigned MID_W    = SRC_W - 1 - LONG_W;
   localparam logic [WORD_W-1:0] POS_W = {1'b0, {(WORD_W-1){1'b1}}};
   localparam logic [WORD_W-1:0] NEG_W = {1'b1, {(WORD_W-1){1'b0}}};

   initial begin
      assert (LANES >= 2 && (LANES % 2) == 0)
         else $error("xfer_lim_bus: LANES must be even and non-zero");
      assert (SRC_W >= LONG_W + 2)
         else $error("xfer_lim_bus: SRC_W must exceed twice WORD_W plus guard bit");
   end

   logic [WORD_W-1:0] short_word [LANES];
   logic [LANES-1:0]  short_hit;
   logic [LONG_W-1:0] long_word  [PAIRS];
   logic [PAIRS-1:0]  long_hit;
   logic [LANES*WORD_W-1:0] nxt_word;
   logic [LANES-1:0]        nxt_sat;

   // word limiters, one per lane
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [SRC_W-1:0] lane_src;
      logic [MID_W-1:0] unused_mid;
      assign lane_src   = src_i[l*SRC_W +: SRC_W];
      assign unused_mid = lane_src[SIGN_BIT-1 -: MID_W];

      xfer_lim_cell #(.OUT_W(WORD_W)) u_cell (
         .sign_i (lane_src[SIGN_BIT]),
         .pass_i (lane_src[PASS_MSB -: WORD_W]),
         .flag_i (flag_i[l]),
         .en_i   (en_i[l]),
         .word_o (short_word[l]),
         .hit_o  (short_hit[l])
      );
   end

   // long limiters, fed by the even lane of each pair
   for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      logic [SRC_W-1:0] pair_src;
      assign pair_src = src_i[(2*p)*SRC_W +: SRC_W];

      xfer_lim_cell #(.OUT_W(LONG_W)) u_cell (
         .sign_i (pair_src[SIGN_BIT]),
         .pass_i (pair_src[PASS_MSB:0]),
         .flag_i (flag_i[2*p]),
         .en_i   (en_i[2*p]),
         .word_o (long_word[p]),
         .hit_o  (long_hit[p])
      );
   end

   // mode mux: even lane takes the low half of its pair, odd lane the high half
   for (genvar l = 0; l < LANES; l++) begin : g_mux
      localparam int unsigned PR   = l / 2;
      localparam int unsigned HALF = l % 2;
      always_comb begin
         if (xfer_mode_e'(long_i) == MODE_LONG) begin
            nxt_word[l*WORD_W +: WORD_W] = long_word[PR][HALF*WORD_W +: WORD_W];
            nxt_sat[l]                   = long_hit[PR];
         end else begin
            nxt_word[l*WORD_W +: WORD_W] = short_word[l];
            nxt_sat[l]                   = short_hit[l];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o <= '0;
         sat_o  <= '0;
      end else begin
         word_o <= nxt_word;
         sat_o  <= nxt_sat;
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (word_o == '0 && sat_o == '0));

   for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
      // R2
      word_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!long_i && en_i[l] && flag_i[l] && !src_i[l*SRC_W + SIGN_BIT])
         |=> (sat_o[l] && word_o[l*WORD_W +: WORD_W] == POS_W));
      // R3
      word_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!long_i && en_i[l] && flag_i[l] && src_i[l*SRC_W + SIGN_BIT])
         |=> (sat_o[l] && word_o[l*WORD_W +: WORD_W] == NEG_W));
      // R4
      word_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!long_i && !(en_i[l] && flag_i[l]))
         |=> (!sat_o[l] && word_o[l*WORD_W +: WORD_W]
              == $past(src_i[l*SRC_W + PASS_MSB -: WORD_W])));
   end

   for (genvar p = 0; p < PAIRS; p++) begin : g_pair_chk
      // R5
      long_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (long_i && en_i[2*p] && flag_i[2*p])
         |=> (word_o[(2*p+1)*WORD_W +: WORD_W]
              == ($past(src_i[(2*p)*SRC_W + SIGN_BIT]) ? NEG_W : POS_W)));
      // R11
      long_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         long_i |=> (sat_o[2*p] == sat_o[2*p+1]
                     && sat_o[2*p] == $past(en_i[2*p] && flag_i[2*p])));
   end

endmodule

// File: rtl/xfer_lim_top.sv
// Two (NUM_BUS) limiter buses side by side on flat port vectors.
module xfer_lim_top
   import xfer_lim_pkg::*;
#(
   parameter int unsigned NUM_BUS = DEF_NUM_BUS,
   parameter int unsigned LANES   = DEF_LANES,
   parameter int unsigned SRC_W   = DEF_SRC_W,
   parameter int unsigned WORD_W  = DEF_WORD_W
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_BUS-1:0]              long_i,
   input  logic [NUM_BUS*LANES*SRC_W-1:0]  src_i,
   input  logic [NUM_BUS*LANES-1:0]        flag_i,
   input  logic [NUM_BUS*LANES-1:0]        en_i,
   output logic [NUM_BUS*LANES*WORD_W-1:0] word_o,
   output logic [NUM_BUS*LANES-1:0]        sat_o
);

   localparam int unsigned BUS_SRC_W  = LANES * SRC_W;
   localparam int unsigned BUS_WORD_W = LANES * WORD_W;

   initial begin
      assert (NUM_BUS >= 1) else $error("xfer_lim_top: NUM_BUS must be at least 1");
   end

   for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
      xfer_lim_bus #(
         .LANES  (LANES),
         .SRC_W  (SRC_W),
         .WORD_W (WORD_W)
      ) u_bus (
         .clk    (clk),
         .rst_n  (rst_n),
         .long_i (long_i[b]),
         .src_i  (src_i[b*BUS_SRC_W +: BUS_SRC_W]),
         .flag_i (flag_i[b*LANES +: LANES]),
         .en_i   (en_i[b*LANES +: LANES]),
         .word_o (word_o[b*BUS_WORD_W +: BUS_WORD_W]),
         .sat_o  (sat_o[b*LANES +: LANES])
      );
   end

endmodule

// File: tb/xfer_lim_top_bench.sv
`timescale 1ns/1ps
module xfer_lim_top_bench;

   localparam int NL = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   long_i = '0;
   logic [319:0] src_i = '0;
   logic [7:0]   flag_i = '0;
   logic [7:0]   en_i = '0;
   logic [127:0] word_o;
   logic [7:0]   sat_o;

   logic [39:0] s [NL];
   logic [7:0]  fl, en;
   logic [1:0]  lg;
   int tests = 0, fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   xfer_lim_top u_xfer_lim_top (
      .clk(clk), .rst_n(rst_n), .long_i(long_i), .src_i(src_i),
      .flag_i(flag_i), .en_i(en_i), .word_o(word_o), .sat_o(sat_o));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_word(int i);
      int b = i / 4;
      int e = b * 4 + ((i % 4) / 2) * 2;
      logic [31:0] v;
      if (lg[b]) begin
         v = (en[e] && fl[e]) ? (s[e][39] ? 32'h8000_0000 : 32'h7FFF_FFFF) : s[e][31:0];
         return (i % 2) ? v[31:16] : v[15:0];
      end
      return (en[i] && fl[i]) ? (s[i][39] ? 16'h8000 : 16'h7FFF) : s[i][31:16];
   endfunction

   function automatic logic exp_sat(int i);
      int b = i / 4;
      int e = b * 4 + ((i % 4) / 2) * 2;
      return lg[b] ? (en[e] && fl[e]) : (en[i] && fl[i]);
   endfunction

   task automatic drive();
      for (int i = 0; i < NL; i++) src_i[i*40 +: 40] = s[i];
      flag_i = fl; en_i = en; long_i = lg;
   endtask

   task automatic apply();
      @(negedge clk); drive();
      @(posedge clk); #1;
   endtask

   task automatic check_all(string req);
      for (int i = 0; i < NL; i++) begin
         chk(req, {16'h0, word_o[i*16 +: 16]}, {16'h0, exp_word(i)});
         chk(req, {31'h0, sat_o[i]}, {31'h0, exp_sat(i)});
      end
   endtask

   task automatic clear_all();
      for (int i = 0; i < NL; i++) s[i] = 40'h0;
      fl = '0; en = '0; lg = '0;
   endtask

   task automatic t_reset();
      clear_all();
      for (int i = 0; i < NL; i++) s[i] = 40'h7F_1234_5678;
      fl = '1; en = '1;
      drive();
      repeat (3) @(posedge clk);
      #1;
      chk("R1 word", word_o[31:0], 32'h0);
      chk("R1 sat", {24'h0, sat_o}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 first edge", {16'h0, word_o[15:0]}, 32'h7FFF);
   endtask

   task automatic t_word_sat();
      clear_all();
      s[0] = 40'h00_1234_5678; s[1] = 40'h7F_FFFF_FFFF;
      s[2] = 40'hFF_0000_0000; s[3] = 40'h80_0000_0000;
      fl = 8'h0F; en = 8'h0F;
      apply();
      chk("R2 lane0", {16'h0, word_o[15:0]},  32'h7FFF);
      chk("R2 R8 lane1", {16'h0, word_o[31:16]}, 32'h7FFF);
      chk("R3 lane2", {16'h0, word_o[47:32]}, 32'h8000);
      chk("R3 R8 lane3", {16'h0, word_o[63:48]}, 32'h8000);
      chk("R2 sat", {28'h0, sat_o[3:0]}, 32'hF);
      check_all("R2 R3 all");
   endtask

   task automatic t_word_pass();
      clear_all();
      s[0] = 40'h80_ABCD_1111; s[1] = 40'h00_5555_2222;
      s[2] = 40'hC3_9876_3333; s[3] = 40'h01_0102_4444;
      fl = 8'h05; en = 8'h0A;
      apply();
      chk("R4 en low", {16'h0, word_o[15:0]},  32'hABCD);
      chk("R4 flag low", {16'h0, word_o[31:16]}, 32'h5555);
      chk("R4 sat", {28'h0, sat_o[3:0]}, 32'h0);
      check_all("R4 all");
   endtask

   task automatic t_long();
      clear_all();
      lg = 2'b10;
      s[4] = 40'h00_1234_5678; s[6] = 40'h80_0000_0001;
      s[5] = 40'h80_0000_0000; s[7] = 40'h00_0000_0000;
      fl = 8'hF0; en = 8'hF0;
      apply();
      chk("R5 pos", word_o[95:64],  32'h7FFF_FFFF);
      chk("R5 neg", word_o[127:96], 32'h8000_0000);
      chk("R11 sat", {24'h0, sat_o}, 32'hF0);
      check_all("R5 R11 all");
   endtask

   task automatic t_long_pass();
      clear_all();
      lg = 2'b11;
      s[0] = 40'h12_89AB_CDEF; s[2] = 40'hF0_0102_0304;
      s[4] = 40'h80_7FFF_0000; s[6] = 40'h00_8000_FFFF;
      fl = 8'h55;
      apply();
      chk("R6 bus0 pair0", word_o[31:0],  32'h89AB_CDEF);
      chk("R6 bus1 pair1", word_o[127:96], 32'h8000_FFFF);
      chk("R6 sat", {24'h0, sat_o}, 32'h0);
      check_all("R6 all");
   endtask

   task automatic t_long_odd();
      clear_all();
      lg = 2'b11;
      s[0] = 40'h00_1111_2222; s[1] = 40'h80_3333_4444;
      s[2] = 40'h80_5555_6666; s[3] = 40'h00_7777_8888;
      fl = 8'h06; en = 8'h06;
      apply();
      chk("R7 odd ignored", word_o[31:0], 32'h1111_2222);
      chk("R7 even wins", word_o[63:32], 32'h8000_0000);
      chk("R7 sat", {28'h0, sat_o[3:0]}, 32'hC);
      check_all("R7 all");
   endtask

   task automatic t_mixed();
      logic [63:0] r = 64'h9E37_79B9_7F4A_7C15;
      for (int n = 0; n < 40; n++) begin
         for (int i = 0; i < NL; i++) begin
            r = r ^ (r << 13); r = r ^ (r >> 7); r = r ^ (r << 17);
            s[i] = r[39:0];
         end
         r = r ^ (r << 13); r = r ^ (r >> 7); r = r ^ (r << 17);
         fl = r[7:0]; en = r[15:8]; lg = r[17:16];
         apply();
         check_all("R9 mixed");
      end
   endtask

   task automatic t_latency();
      logic [15:0] old0;
      clear_all();
      s[0] = 40'h00_ABCD_0000;
      apply();
      old0 = exp_word(0);
      fl[0] = 1'b1; en[0] = 1'b1;
      @(negedge clk); drive(); #1;
      chk("R10 hold", {16'h0, word_o[15:0]}, {16'h0, old0});
      chk("R10 hold sat", {31'h0, sat_o[0]}, 32'h0);
      @(posedge clk); #1;
      chk("R10 update", {16'h0, word_o[15:0]}, 32'h7FFF);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog act=running exp=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_word_sat();
      t_word_pass();
      t_long();
      t_long_pass();
      t_long_odd();
      t_mixed();
      t_latency();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule